// File: doc/BRIEF.md
# Real-Time Clock with Tick-Synchronized Register Writes

This block keeps wall-clock time as a packed day/hour/minute/second word, advanced by a slow oscillator input that is sampled in the bus clock domain. When the divider is on, the oscillator is divided down to a once-per-second count tick. When it is off, every oscillator rising edge is a count tick. Alongside the time word it holds an alarm word, a countdown stopwatch, an interrupt-enable mask, a divider switch and a sticky event-status word. It drives the status word and a single interrupt line.

Writes to the timekeeping registers are not applied at once. A write is parked in a one-entry holding slot and marked pending, and it lands on the next count tick. Any other timekeeping write that arrives while the slot is occupied is thrown away. Software must therefore wait for the pending flag to drop, or for the sticky completion flag, before writing again. Status clears bypass the holding slot and act in the cycle they are written.

Top module: `rtc_sync_core`

## Requirements
- R1: Address 0 reads the time word: seconds in bits [5:0], minutes in [11:6], hours in [16:12], days in [31:17]. On each count tick that does not load the time, the word advances as follows. Seconds go from 59 to 0 and carry into minutes, and any other seconds value adds one modulo 64. Minutes go from 59 to 0 and carry into hours. Hours go from 23 to 0 and carry into days. Days wrap from 32767 to 0.
- R2: Address 4 bit 0 is the divider switch. With the switch clear, each osc_i rising edge is a count tick. With the switch set, every DIV-th rising edge is a count tick, and the edge counter is held at zero while the switch is clear. A rising edge first sampled high at a clock edge acts SYNC_STAGES clock edges later.
- R3: A bus write to address 0 (time), 1 (alarm), 2 (enable), 4 (divider) or 5 (stopwatch) that arrives while nothing is pending sets the pending flag (status bit 14) from the next cycle. The target keeps reading its old value until the next count tick commits the write.
- R4: A write to any of those five addresses that arrives while the pending flag is set is discarded and leaves no trace.
- R5: When a count tick finds a write pending, the write lands, the pending flag clears, and sticky status bit 15 (write complete) is set.
- R6: Address 3 is the status word. Writing a 1 clears that bit in the same cycle. Bit 14 ignores the write. An event that sets a bit in the same cycle wins over the clear. Writes to addresses 6 and 7 have no effect.
- R7: On a count tick that does not load the time, status bit 2 is set. Bit 3 is set when seconds wrap from 59, bit 4 when minutes wrap, and bit 5 when hours wrap. These bits are set whatever the enable mask holds.
- R8: On such a tick, bit 1 is set if the new hours, minutes and seconds equal those of the alarm word held before the tick. Bit 6 is set if the whole new time word equals the alarm word.
- R9: The stopwatch at address 5 counts down by one on every count tick while it is nonzero, unless that tick loads it. On the tick where it goes from 1 to 0, status bit 0 is set.
- R10: Address 2 holds a 16-bit enable mask. irq_o is high in every cycle where some status bit, with bit 14 reflecting the pending flag, and the matching enable bit are both set.
- R11: After reset, all registers read zero, the divider is off, nothing is pending, and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_i | input | 1 | Slow oscillator, asynchronous to clk |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_o | output | 16 | Status word, with bit 14 showing the pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The reference model is checked against the design in every cycle, on the read port, the status word and the interrupt line. It is exercised under four kinds of stimulus:

- **Serialized writes**, each issued after the pending flag drops. These show that commits land on the tick, apart from the time advancing.
- **Back-to-back writes.** The second write of each pair must disappear, which separates discard from queueing and from overwrite.
- **A time word preset just before the day counter's top value.** This drives every carry and the day wrap, and shows whether the alarm compares the hour/minute/second fields or the whole word.
- **A long stream of random addresses, data and status clears, with the divider toggled.** This makes tick, commit and clear collide in the same cycle, which tests the same-cycle priorities.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int TW = 32;
   localparam int SW = 16;

   typedef enum logic [2:0] {
      RA_TIME   = 3'd0,
      RA_ALARM  = 3'd1,
      RA_IEN    = 3'd2,
      RA_STAT   = 3'd3,
      RA_PREN   = 3'd4,
      RA_SWATCH = 3'd5
   } rtc_addr_e;

   localparam int ST_SWATCH = 0;
   localparam int ST_ALARM  = 1;
   localparam int ST_SEC    = 2;
   localparam int ST_MIN    = 3;
   localparam int ST_HOUR   = 4;
   localparam int ST_DAY    = 5;
   localparam int ST_DALARM = 6;
   localparam int ST_PEND   = 14;
   localparam int ST_DONE   = 15;

   localparam int SEC_LO  = 0;
   localparam int MIN_LO  = 6;
   localparam int HOUR_LO = 12;
   localparam int DAY_LO  = 17;
   localparam int SEC_W   = MIN_LO - SEC_LO;
   localparam int MIN_W   = HOUR_LO - MIN_LO;
   localparam int HOUR_W  = DAY_LO - HOUR_LO;
   localparam int DAY_W   = TW - DAY_LO;

   function automatic logic is_synced(input logic [2:0] a);
      return (a == RA_TIME) || (a == RA_ALARM) || (a == RA_IEN) ||
             (a == RA_PREN) || (a == RA_SWATCH);
   endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
   parameter int DIV         = 32768,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_i,
   input  logic pren_i,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   initial begin
      assert (DIV >= 2) else $error("rtc_tick_gen: DIV must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("rtc_tick_gen: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [CW-1:0]          cnt_q;
   logic                   rise;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= osc_i;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) sync_q[gi] <= 1'b0;
               else        sync_q[gi] <= sync_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !pren_i) cnt_q <= '0;
      else if (rise)         cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assign tick_o = rise & (~pren_i | (cnt_q == LAST));

endmodule

// File: rtl/rtc_wr_hold.sv
module rtc_wr_hold #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [2:0]    addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          tick_i,
   output logic          pend_o,
   output logic          commit_o,
   output logic [2:0]    c_addr_o,
   output logic [DW-1:0] c_data_o
);
   import rtc_pkg::*;

   logic          pend_q;
   logic [2:0]    addr_q;
   logic [DW-1:0] data_q;
   logic          accept;

   assign accept   = wr_i & is_synced(addr_i) & ~pend_q;
   assign commit_o = tick_i & pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         pend_q <= 1'b1;
         addr_q <= addr_i;
         data_q <= wdata_i;
      end else if (commit_o) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o   = pend_q;
   assign c_addr_o = addr_q;
   assign c_data_o = data_q;

endmodule

// File: rtl/rtc_time_ctr.sv
module rtc_time_ctr (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic                  load_i,
   input  logic [rtc_pkg::TW-1:0] load_val_i,
   input  logic [rtc_pkg::TW-1:0] alarm_i,
   output logic [rtc_pkg::TW-1:0] time_o,
   output logic                  ev_sec_o,
   output logic                  ev_min_o,
   output logic                  ev_hour_o,
   output logic                  ev_day_o,
   output logic                  ev_alarm_o,
   output logic                  ev_dalarm_o
);
   import rtc_pkg::*;

   logic [TW-1:0]     time_q, inc_val;
   logic [SEC_W-1:0]  sec, n_sec;
   logic [MIN_W-1:0]  mins, n_min;
   logic [HOUR_W-1:0] hr, n_hr;
   logic [DAY_W-1:0]  day, n_day;
   logic              sec_wrap, min_wrap, hr_wrap, adv;

   assign sec  = time_q[SEC_LO  +: SEC_W];
   assign mins = time_q[MIN_LO  +: MIN_W];
   assign hr   = time_q[HOUR_LO +: HOUR_W];
   assign day  = time_q[DAY_LO  +: DAY_W];

   assign sec_wrap = (sec == SEC_W'(59));
   assign min_wrap = sec_wrap && (mins == MIN_W'(59));
   assign hr_wrap  = min_wrap && (hr == HOUR_W'(23));

   always_comb begin
      n_sec = sec_wrap ? '0 : sec + 1'b1;
      n_min = mins;
      if (sec_wrap) n_min = (mins == MIN_W'(59)) ? '0 : mins + 1'b1;
      n_hr = hr;
      if (min_wrap) n_hr = (hr == HOUR_W'(23)) ? '0 : hr + 1'b1;
      n_day = hr_wrap ? day + 1'b1 : day;
      inc_val = {n_day, n_hr, n_min, n_sec};
   end

   assign adv = tick_i & ~load_i;

   always_ff @(posedge clk) begin
      if (!rst_n)      time_q <= '0;
      else if (load_i) time_q <= load_val_i;
      else if (adv)    time_q <= inc_val;
   end

   assign ev_sec_o    = adv;
   assign ev_min_o    = adv & sec_wrap;
   assign ev_hour_o   = adv & min_wrap;
   assign ev_day_o    = adv & hr_wrap;
   assign ev_alarm_o  = adv & (inc_val[DAY_LO-1:0] == alarm_i[DAY_LO-1:0]);
   assign ev_dalarm_o = adv & (inc_val == alarm_i);
   assign time_o      = time_q;

endmodule

// File: rtl/rtc_swatch.sv
module rtc_swatch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o,
   output logic         ev_zero_o
);
   logic [W-1:0] cnt_q;
   logic         dec;

   assign dec = tick_i & ~load_i & (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec)    cnt_q <= cnt_q - 1'b1;
   end

   assign ev_zero_o = dec & (cnt_q == W'(1));
   assign cnt_o     = cnt_q;

endmodule

// File: rtl/rtc_sync_core.sv
module rtc_sync_core #(
   parameter int DIV         = 32768,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        osc_i,
   input  logic        bus_wr,
   input  logic [2:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic [15:0] evt_o,
   output logic        irq_o
);
   import rtc_pkg::*;

   localparam logic [SW-1:0] KEEP_MASK = ~(SW'(1) << ST_PEND);

   logic          tick, pend, commit;
   logic [2:0]    c_addr;
   logic [TW-1:0] c_data, time_w, sw_cnt;
   logic [TW-1:0] alarm_q;
   logic [SW-1:0] ien_q, status_q, set_vec;
   logic          pren_q, load_time, load_sw;
   logic          ev_sec, ev_min, ev_hour, ev_day, ev_alarm, ev_dalarm, ev_sw;

   rtc_tick_gen #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .osc_i(osc_i), .pren_i(pren_q), .tick_o(tick)
   );

   rtc_wr_hold #(.DW(TW)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .tick_i(tick), .pend_o(pend), .commit_o(commit),
      .c_addr_o(c_addr), .c_data_o(c_data)
   );

   assign load_time = commit && (c_addr == RA_TIME);
   assign load_sw   = commit && (c_addr == RA_SWATCH);

   rtc_time_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load_time),
      .load_val_i(c_data), .alarm_i(alarm_q), .time_o(time_w),
      .ev_sec_o(ev_sec), .ev_min_o(ev_min), .ev_hour_o(ev_hour),
      .ev_day_o(ev_day), .ev_alarm_o(ev_alarm), .ev_dalarm_o(ev_dalarm)
   );

   rtc_swatch #(.W(TW)) u_sw (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(load_sw),
      .load_val_i(c_data), .cnt_o(sw_cnt), .ev_zero_o(ev_sw)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alarm_q <= '0;
         ien_q   <= '0;
         pren_q  <= 1'b0;
      end else if (commit) begin
         case (c_addr)
            RA_ALARM: alarm_q <= c_data;
            RA_IEN:   ien_q   <= c_data[SW-1:0];
            RA_PREN:  pren_q  <= c_data[0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      set_vec            = '0;
      set_vec[ST_SWATCH] = ev_sw;
      set_vec[ST_ALARM]  = ev_alarm;
      set_vec[ST_SEC]    = ev_sec;
      set_vec[ST_MIN]    = ev_min;
      set_vec[ST_HOUR]   = ev_hour;
      set_vec[ST_DAY]    = ev_day;
      set_vec[ST_DALARM] = ev_dalarm;
      set_vec[ST_DONE]   = commit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= '0;
      else if (bus_wr && bus_addr == RA_STAT)
         status_q <= ((status_q & ~bus_wdata[SW-1:0]) | set_vec) & KEEP_MASK;
      else
         status_q <= (status_q | set_vec) & KEEP_MASK;
   end

   always_comb begin
      evt_o          = status_q;
      evt_o[ST_PEND] = pend;
   end

   assign irq_o = |(evt_o & ien_q);

   always_comb begin
      case (bus_addr)
         RA_TIME:   bus_rdata = time_w;
         RA_ALARM:  bus_rdata = alarm_q;
         RA_IEN:    bus_rdata = {{(32-SW){1'b0}}, ien_q};
         RA_STAT:   bus_rdata = {{(32-SW){1'b0}}, evt_o};
         RA_PREN:   bus_rdata = {31'b0, pren_q};
         RA_SWATCH: bus_rdata = sw_cnt;
         default:   bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/rtc_sync_chk.sv
module rtc_sync_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tick,
   input logic        pend,
   input logic        load_time,
   input logic        load_sw,
   input logic [31:0] sw_cnt,
   input logic [15:0] ien,
   input logic        bus_wr,
   input logic [2:0]  bus_addr,
   input logic [31:0] bus_wdata,
   input logic [15:0] evt_o,
   input logic        irq_o
);
   import rtc_pkg::*;

   // R3
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && is_synced(bus_addr) && !pend) |=> evt_o[ST_PEND]);

   // R4
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !tick) |=> evt_o[ST_PEND]);

   // R5
   commit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && tick) |=> (!evt_o[ST_PEND] && evt_o[ST_DONE]));

   // R6
   w1c_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_STAT && bus_wdata[ST_MIN] && !tick) |=> !evt_o[ST_MIN]);

   // R7
   sec_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_time) |=> evt_o[ST_SEC]);

   // R9
   sw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load_sw && sw_cnt == 32'd1) |=> (evt_o[ST_SWATCH] && sw_cnt == 32'd0));

   // R10
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == 16'd0) |-> !irq_o);

endmodule

bind rtc_sync_core rtc_sync_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend), .load_time(load_time),
   .load_sw(load_sw), .sw_cnt(sw_cnt), .ien(ien_q), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt_o(evt_o), .irq_o(irq_o)
);

// File: tb/sim_rtc_sync_core.sv
module sim_rtc_sync_core;
   localparam int DIV = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_i = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = 3'd0;
   logic [31:0] bus_wdata = 32'd0;
   logic [31:0] bus_rdata;
   logic [15:0] evt_o;
   logic        irq_o;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int rot    = 0;

   always #5 clk = ~clk;

   rtc_sync_core #(.DIV(DIV), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .osc_i(osc_i), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_o(evt_o), .irq_o(irq_o)
   );

   // ---------------- reference model ----------------
   bit          h1, h2, h3;
   int          m_cnt;
   bit          m_pren, m_pend;
   int unsigned m_paddr, m_pdata;
   int unsigned m_time, m_alarm, m_sw;
   bit [15:0]   m_ien, m_stat;

   function automatic int unsigned next_time(input int unsigned t);
      int unsigned s, mi, hr, dy;
      s  = t & 63;
      mi = (t >> 6) & 63;
      hr = (t >> 12) & 31;
      dy = (t >> 17) & 32767;
      if (s == 59) begin
         s = 0;
         if (mi == 59) begin
            mi = 0;
            if (hr == 23) begin
               hr = 0;
               dy = (dy + 1) % 32768;
            end else hr = hr + 1;
         end else mi = mi + 1;
      end else s = (s + 1) % 64;
      return (dy << 17) | (hr << 12) | (mi << 6) | s;
   endfunction

   always @(posedge clk) begin
      bit edge_s, tick, commit, adv;
      bit [15:0] setv, st;
      int unsigned nt;
      if (!rst_n) begin
         h1 = 0; h2 = 0; h3 = 0; m_cnt = 0; m_pren = 0; m_pend = 0;
         m_paddr = 0; m_pdata = 0; m_time = 0; m_alarm = 0; m_sw = 0;
         m_ien = 0; m_stat = 0;
      end else begin
         edge_s = h2 && !h3;
         tick   = edge_s && (!m_pren || m_cnt == DIV - 1);
         h3 = h2; h2 = h1; h1 = osc_i;
         if (!m_pren) m_cnt = 0;
         else if (edge_s) m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
         commit = tick && m_pend;
         adv    = tick && !(commit && m_paddr == 0);
         setv   = 16'd0;
         if (adv) begin
            nt = next_time(m_time);
            setv[2] = 1'b1;
            setv[3] = ((m_time & 63) == 59);
            setv[4] = ((m_time & 63) == 59) && (((m_time >> 6) & 63) == 59);
            setv[5] = setv[4] && (((m_time >> 12) & 31) == 23);
            setv[1] = ((nt & 32'h1FFFF) == (m_alarm & 32'h1FFFF));
            setv[6] = (nt == m_alarm);
            m_time  = nt;
         end
         if (commit) setv[15] = 1'b1;
         if (commit && m_paddr == 5) m_sw = m_pdata;
         else if (tick && m_sw != 0) begin
            if (m_sw == 1) setv[0] = 1'b1;
            m_sw = m_sw - 1;
         end
         st = m_stat;
         if (bus_wr && bus_addr == 3) st = st & ~bus_wdata[15:0];
         st = st | setv;
         st[14] = 1'b0;
         m_stat = st;
         if (commit) begin
            case (m_paddr)
               0: m_time  = m_pdata;
               1: m_alarm = m_pdata;
               2: m_ien   = m_pdata[15:0];
               4: m_pren  = m_pdata[0];
               default: ;
            endcase
            m_pend = 0;
         end else if (bus_wr && m_pend == 0 &&
                      (bus_addr == 0 || bus_addr == 1 || bus_addr == 2 ||
                       bus_addr == 4 || bus_addr == 5)) begin
            m_pend  = 1;
            m_paddr = bus_addr;
            m_pdata = bus_wdata;
         end
      end
   end

   function automatic bit [15:0] m_evt();
      bit [15:0] e;
      e = m_stat;
      e[14] = m_pend;
      return e;
   endfunction

   function automatic int unsigned m_read(input int a);
      case (a)
         0: return m_time;
         1: return m_alarm;
         2: return {16'd0, m_ien};
         3: return {16'd0, m_evt()};
         4: return {31'd0, m_pren};
         5: return m_sw;
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input int unsigned act, input int unsigned exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // per-clock comparison, sampled after the edge has settled
   always @(posedge clk) begin
      cyc++;
      #2;
      if (rst_n) begin
         string tg;
         case (bus_addr)
            3'd0: tg = "R1 time";
            3'd1: tg = "R8 alarm";
            3'd2: tg = "R10 enable";
            3'd3: tg = "R6 status";
            3'd4: tg = "R2 divider";
            3'd5: tg = "R9 stopwatch";
            default: tg = "R6 unused addr";
         endcase
         check("R7 evt_o", {16'd0, evt_o}, {16'd0, m_evt()});
         check("R10 irq_o", {31'd0, irq_o}, {31'd0, |(m_evt() & m_ien)});
         check(tg, bus_rdata, m_read(int'(bus_addr)));
      end
   end

   // oscillator: period of four bus cycles
   initial begin
      forever begin
         repeat (2) @(negedge clk);
         osc_i = ~osc_i;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         bus_wr = 1'b0;
         bus_addr = 3'(rot);
         rot = (rot + 1) % 8;
      end
   endtask

   task automatic wr(input int a, input int unsigned d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_addr = 3'(a);
      bus_wdata = d;
   endtask

   task automatic wait_idle();
      int guard = 0;
      idle(1);
      while (evt_o[14] && guard < 200) begin
         idle(1);
         guard++;
      end
   endtask

   task automatic rd(input int a, output int unsigned v);
      @(negedge clk);
      bus_wr = 1'b0;
      bus_addr = 3'(a);
      #1 v = bus_rdata;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   // ---------------- directed and random sequence ----------------
   initial begin
      int unsigned v, s1, s2;
      int guard;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      rd(0, v); check("R11 time after reset", v, 0);
      rd(4, v); check("R11 divider after reset", v, 0);
      check("R11 evt after reset", {16'd0, evt_o}, 0);
      check("R11 irq after reset", {31'd0, irq_o}, 0);

      // R3: alarm write parks, old value until tick
      wr(1, 32'd1);
      rd(1, v);
      check("R3 pending flag", {31'd0, evt_o[14]}, 1);
      check("R3 old alarm before tick", v, 0);
      wait_idle();
      // R5: completion sticky
      check("R5 write complete", {31'd0, evt_o[15]}, 1);
      rd(1, v); check("R5 alarm landed", v, 1);
      // R6: W1C immediate
      wr(3, 32'h8000);
      idle(1);
      check("R6 done cleared", {31'd0, evt_o[15]}, 0);

      // R4: second write while pending is dropped
      wr(0, (32767 << 17) | (23 << 12) | (59 << 6) | 57);
      wr(1, 32'd5);
      wait_idle();
      wait_idle();
      rd(1, v); check("R4 dropped alarm write", v, 1);

      // R1/R8: day wrap then full alarm match at day 0 00:00:01
      wr(3, 32'hFFFF);
      guard = 0;
      idle(1);
      while (!evt_o[6] && guard < 400) begin idle(1); guard++; end
      check("R8 day alarm seen", {31'd0, evt_o[6]}, 1);
      check("R8 alarm seen", {31'd0, evt_o[1]}, 1);
      check("R7 day rollover seen", {31'd0, evt_o[5]}, 1);
      rd(0, v); check("R1 wrapped time", v, 32'd1);

      // R10: enable day-alarm bit
      wr(2, 32'h0040);
      wait_idle();
      idle(1);
      check("R10 irq raised", {31'd0, irq_o}, 1);
      wr(3, 32'hFFFF);
      idle(1);
      check("R10 irq dropped after clear", {31'd0, irq_o}, 0);

      // R9: stopwatch countdown
      wr(5, 32'd3);
      wait_idle();
      guard = 0;
      while (!evt_o[0] && guard < 400) begin idle(1); guard++; end
      check("R9 stopwatch event", {31'd0, evt_o[0]}, 1);
      rd(5, v); check("R9 stopwatch at zero", v, 0);

      // R2: divider on, tick every DIV oscillator periods
      wr(4, 32'd1);
      wait_idle();
      idle(5);
      rd(0, s1);
      idle(4 * DIV * 4 - 1);
      rd(0, s2);
      check("R2 divided rate", ((s2 & 63) + 60 - (s1 & 63)) % 60, 4);
      wr(4, 32'd0);
      wait_idle();

      // random stream: collisions of tick, commit and clear
      for (int i = 0; i < 3000; i++) begin
         int unsigned r = $urandom;
         if (r[2:0] == 3'd0) wr(int'(r[5:3]), $urandom);
         else if (r[2:0] == 3'd1) wr(3, $urandom);
         else idle(1);
      end
      idle(4);

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule